// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides a fast input clock by a programmable integer ratio. A dual-modulus prescaler divides by 8 or 9. It is built from a three-flop 4/5 core, a divide-by-2 stage advanced by the core's wrap event, and a NAND gate that combines the divide-by-2 state with a modulus-select line. Two down-counters run on the prescaler's cycle events. The main counter sets how many prescaler cycles make up one output period. The swallow counter sets how many of those cycles use the longer modulus. The output period is therefore `8*M + W` input cycles, where M is the main count and W is the swallow count.

Both settings are taken from the input ports only at an output-period boundary, in the same cycle that the output pulse is produced. A change in mid-period therefore never shortens or stretches the period that is running. Out-of-range settings are saturated: a main count of zero acts as one, and a swallow count larger than the main count acts as the main count. The output is a single-cycle pulse once per period, and periods follow one another with no gap. The whole block runs on the input clock. The divide-by-2 stage is modelled as an enabled toggle rather than as a separate clock.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high, `div_out` is 0. After `rst` falls, the first `div_out` pulse appears on the 8th rising clock edge.
- R2: The number of input cycles between consecutive `div_out` pulses equals `8*M + W`, using the effective M and W loaded at the earlier pulse.
- R3: With W = 0 the period is exactly `8*M` cycles.
- R4: With W = M the period is exactly `9*M` cycles.
- R5: A `swallow_count` greater than the effective M is treated as M.
- R6: A `mod_count` of 0 is treated as 1.
- R7: `mod_count` and `swallow_count` are sampled only on the clock edge that raises `div_out`. Values applied at any other time in a period have no effect on that period.
- R8: `div_out` is high for exactly one clock cycle per period.
- R9: Each prescaler cycle lasts 8 input cycles, or 9 when modulus-select was active at the event that started it. One swallowed cycle adds exactly one input cycle to the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_count | input | S_W | Main count M: prescaler cycles per output period |
| swallow_count | input | 3 | Swallow count W: divide-by-9 cycles per period |
| div_out | output | 1 | One-cycle pulse per output period |

## Verification
The assertions assume that the settings only change away from the sampling edge, or that any change is intended for the next period. They also assume that the prescaler core starts from its reset state, so that the two illegal core states are never entered. The stimulus changes the settings only on falling edges. It does so either right after a pulse, or a few cycles into a period after writing deliberately wrong values first. This means every value the design sees at a boundary is one the bench meant to load. Random settings cover the whole port range, including zero and over-range values, so the saturation paths stay inside the checked behaviour.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int unsigned PRESC_LOW = 8;
  localparam int unsigned SWAL_W    = 3;

  // main count with zero lifted to one
  function automatic int unsigned eff_main(input int unsigned m);
    return (m == 0) ? 1 : m;
  endfunction

  // swallow count clipped to the effective main count
  function automatic int unsigned eff_swallow(input int unsigned m, input int unsigned w);
    int unsigned me;
    me = eff_main(m);
    return (w > me) ? me : w;
  endfunction

  // input cycles per output period
  function automatic int unsigned period_len(input int unsigned m, input int unsigned w);
    return eff_main(m) * PRESC_LOW + eff_swallow(m, w);
  endfunction
endpackage

// File: rtl/swdiv_core45.sv
module swdiv_core45 (
  input  logic clk,
  input  logic rst,
  input  logic ext_mc,
  output logic core_wrap,
  output logic ff1_q,
  output logic ff3_q
);
  logic q1, q2, q3;

  always_ff @(posedge clk) begin
    if (rst) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
      q3 <= 1'b0;
    end else begin
      q1 <= ~(q2 | q3);
      q2 <= q1;
      q3 <= q2 & ext_mc;
    end
  end

  // last state of a core cycle: second flop high, first low
  assign core_wrap = q2 & ~q1;
  assign ff1_q     = q1;
  assign ff3_q     = q3;

  // R9
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    !(ff1_q && ff3_q));
endmodule

// File: rtl/swdiv_prescaler89.sv
module swdiv_prescaler89 (
  input  logic clk,
  input  logic rst,
  input  logic mod_sel,
  output logic pre_evt
);
  logic half_q;
  logic nand_n;
  logic core_mc;
  logic core_wrap;
  logic ff1_q, ff3_q;

  assign nand_n  = ~(half_q & mod_sel);
  assign core_mc = ~nand_n;

  swdiv_core45 u_core (
    .clk      (clk),
    .rst      (rst),
    .ext_mc   (core_mc),
    .core_wrap(core_wrap),
    .ff1_q    (ff1_q),
    .ff3_q    (ff3_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            half_q <= 1'b0;
    else if (core_wrap) half_q <= ~half_q;
  end

  assign pre_evt = core_wrap & half_q;

  // checker state: spacing between prescaler events
  logic [3:0] gap_cnt;
  logic       seen_evt;
  logic       last_long;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt   <= '0;
      seen_evt  <= 1'b0;
      last_long <= 1'b0;
    end else if (pre_evt) begin
      gap_cnt   <= '0;
      seen_evt  <= 1'b1;
      last_long <= mod_sel;
    end else if (gap_cnt != 4'hF) begin
      gap_cnt   <= gap_cnt + 4'd1;
    end
  end

  // R9
  long_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_evt && seen_evt && last_long) |-> (gap_cnt == 4'd8));
  // R9
  short_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_evt && seen_evt && !last_long) |-> (gap_cnt == 4'd7));
  // R9
  hold_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_evt && mod_sel) |=> (!ff1_q && ff3_q));
endmodule

// File: rtl/swdiv_swallow_ctrl.sv
module swdiv_swallow_ctrl #(
  parameter int S_W = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           pre_evt,
  input  logic [S_W-1:0]                 main_set,
  input  logic [swdiv_pkg::SWAL_W-1:0]   swal_set,
  output logic                           mod_sel,
  output logic                           at_bound
);
  import swdiv_pkg::*;

  logic [S_W-1:0] main_rem, swal_rem;
  logic [S_W-1:0] main_ld, swal_ld;
  logic [S_W-1:0] main_base, swal_base;
  logic           upcoming_long;

  assign main_ld = S_W'(eff_main(32'(main_set)));
  assign swal_ld = S_W'(eff_swallow(32'(main_set), 32'(swal_set)));

  assign at_bound      = pre_evt & (main_rem == '0);
  assign main_base     = at_bound ? main_ld : main_rem;
  assign swal_base     = at_bound ? swal_ld : swal_rem;
  assign upcoming_long = (swal_base != '0);
  assign mod_sel       = upcoming_long;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_rem <= '0;
      swal_rem <= '0;
    end else if (pre_evt) begin
      main_rem <= main_base - S_W'(1);
      swal_rem <= swal_base - (upcoming_long ? S_W'(1) : S_W'(0));
    end
  end

  // R2
  swal_within_main_chk: assert property (@(posedge clk) disable iff (rst)
    swal_rem <= main_rem);
  // R7
  hold_between_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pre_evt) |-> ($stable(main_rem) && $stable(swal_rem)));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int S_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [S_W-1:0]               mod_count,
  input  logic [swdiv_pkg::SWAL_W-1:0] swallow_count,
  output logic                         div_out
);
  import swdiv_pkg::*;

  localparam int LEN_W = S_W + 4;

  logic pre_evt;
  logic mod_sel;
  logic at_bound;

  swdiv_prescaler89 u_presc (
    .clk    (clk),
    .rst    (rst),
    .mod_sel(mod_sel),
    .pre_evt(pre_evt)
  );

  swdiv_swallow_ctrl #(.S_W(S_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .pre_evt (pre_evt),
    .main_set(mod_count),
    .swal_set(swallow_count),
    .mod_sel (mod_sel),
    .at_bound(at_bound)
  );

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= at_bound;
  end

  // checker state: period length against the loaded ratio
  logic [LEN_W-1:0] cyc_cnt;
  logic [LEN_W-1:0] exp_len;
  logic             have_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt   <= '0;
      exp_len   <= '0;
      have_prev <= 1'b0;
    end else if (at_bound) begin
      cyc_cnt   <= '0;
      exp_len   <= LEN_W'(period_len(32'(mod_count), 32'(swallow_count)));
      have_prev <= 1'b1;
    end else if (cyc_cnt != '1) begin
      cyc_cnt   <= cyc_cnt + LEN_W'(1);
    end
  end

  // R2
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    (at_bound && have_prev) |-> (cyc_cnt == exp_len - LEN_W'(1)));
  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !div_out);
endmodule

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] s_in = '0;
  logic [2:0]    a_in = '0;
  logic          div_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ld_s, ld_a;
  string ld_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider #(.S_W(SW)) uut (
    .clk(clk), .rst(rst), .mod_count(s_in), .swallow_count(a_in), .div_out(div_out)
  );

  function automatic int want_len(int s, int a);
    int m, w;
    m = (s < 1) ? 1 : s;
    w = (a < m) ? a : m;
    return m * 8 + w;
  endfunction

  function automatic string pick_tag(int s, int a);
    if (s == 0) return "R6";
    if (a > s)  return "R5";
    if (a == 0) return "R3";
    if (a == s) return "R4";
    if (a == 1) return "R9";
    return "R2";
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // counts falling edges until div_out is seen high
  task automatic measure(input bit mid, input int s, input int a, output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (len == 1) chk("R8", int'(div_out), 0);
      if (mid && len == 5) begin
        s_in = SW'(s);
        a_in = 3'(a);
      end
    end while (!div_out && len < 2000);
    if (!div_out) chk("R2 watchdog", len, -1);
  endtask

  task automatic trial(input int s, input int a, input bit mid);
    int len;
    if (mid) begin
      s_in = ~SW'(s);
      a_in = ~3'(a);
    end else begin
      s_in = SW'(s);
      a_in = 3'(a);
    end
    measure(mid, s, a, len);
    chk(ld_tag, len, want_len(ld_s, ld_a));
    ld_s = s;
    ld_a = a;
    ld_tag = mid ? "R7" : pick_tag(s, a);
  endtask

  initial begin
    int first;
    void'($urandom(32'd1357));
    s_in = 6'd3;
    a_in = 3'd2;
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", int'(div_out), 0);
    end
    rst = 1'b0;
    first = 0;
    do begin
      @(negedge clk);
      first++;
    end while (!div_out && first < 100);
    chk("R1", first, 8);
    ld_s = 3; ld_a = 2; ld_tag = "R2";

    trial(1, 0, 1'b0);
    trial(1, 1, 1'b0);
    trial(1, 5, 1'b0);
    trial(0, 3, 1'b0);
    trial(0, 0, 1'b0);
    trial(7, 7, 1'b0);
    trial(8, 0, 1'b0);
    trial(5, 1, 1'b0);
    trial(63, 7, 1'b0);
    trial(2, 7, 1'b1);
    trial(9, 3, 1'b1);
    trial(4, 4, 1'b0);
    for (int k = 0; k < 60; k++) begin
      trial(int'($urandom_range(0, 63)), int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0));
    end
    trial(6, 2, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: got 0 expected 1 completed run");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule